// File: doc/BRIEF.md
# Status Flag ALU with Branch Decision

This block performs an n-bit add, subtract or bitwise AND on two operands, derives four status bits (carry, zero, sign, overflow) from the outcome and keeps them in a status register. Two flag-only operations are also offered. Compare runs the subtraction and test runs the AND, and both refresh the status bits without sending out a result word. A separate 3-bit condition selector is compared with the latched status bits, and a combinational `taken` output reports whether a conditional branch of that kind would be followed. Updating the program counter is left to the surrounding logic.

Operations enter on a valid/ready stream. The handshake completes on any rising edge where `in_valid` and `in_ready` are both high. Results leave on a second valid/ready stream. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer. The output word holds steady while `res_valid` is high and `res_ready` is low. Flag-only operations and unknown codes are accepted but place nothing on the output stream.

Top module: `alu_flag_branch`

## Requirements
- R1: After reset, all four status bits are 0, `res_valid` is 0 and `in_ready` is 1.
- R2: Add (op_sel 0) returns `op_a + op_b` modulo 2^W, and C becomes the carry out of the top bit.
- R3: Subtract (op_sel 1) returns `op_a` plus the two's complement of `op_b`, and C is the carry out of that sum. For example, 0xF0 − 0x14 gives 0xDC with C=1, Z=0, S=1, V=0.
- R4: For add, subtract and compare, V equals the carry into the top bit XOR the carry out of it.
- R5: Z is 1 exactly when every result bit is 0, and S equals the top result bit.
- R6: Compare (op_sel 2) sets the flags exactly as subtract would and produces no output word.
- R7: AND (op_sel 3) returns `op_a & op_b`. Test (op_sel 4) sets the same flags and produces no output word. For both operations C and V are cleared.
- R8: The status register changes only when an operation is accepted with `flag_we` high. An accepted result-producing operation with `flag_we` low still emits its result.
- R9: op_sel codes 5, 6 and 7 are accepted, emit no output word and leave the status bits unchanged.
- R10: The `cond` encoding is 0 zero (Z=1), 1 nonzero (Z=0), 2 carry (C=1), 3 no carry (C=0), 4 plus (S=0), 5 minus (S=1), 6 overflow (V=1), 7 no overflow (V=0). `taken` is evaluated combinationally from the latched flags.
- R11: `in_ready` equals NOT `res_valid` OR `res_ready`. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 compare, 3 AND, 4 test) |
| flag_we | input | 1 | Allow the accepted operation to write the status bits |
| res_valid | output | 1 | Result word present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | W | Result word |
| flag_c | output | 1 | Latched carry |
| flag_z | output | 1 | Latched zero |
| flag_s | output | 1 | Latched sign |
| flag_v | output | 1 | Latched overflow |
| cond | input | 3 | Branch condition selector |
| taken | output | 1 | Branch decision for `cond` |

## Verification
Directed pairs target the arithmetic edges:
- 0x7F+0x01 sets V without C.
- 0xFF+0x01 sets C and Z without V.
- 0x80−0x01 sets V together with C.
- The 0xF0−0x14 case checks the borrow convention.

Equal compares and masked tests that give zero separate the flag-only paths from result writes. A random mix of operations, operand values and write enables then covers sign and carry combinations that directed cases miss, and it also exercises the unknown codes. After every operation all eight branch conditions are swept, so that any inverted or swapped decode shows up.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CMP = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_TST = 3'd4;

  localparam logic [2:0] CC_ZERO  = 3'd0;
  localparam logic [2:0] CC_NZERO = 3'd1;
  localparam logic [2:0] CC_CARRY = 3'd2;
  localparam logic [2:0] CC_NCARRY = 3'd3;
  localparam logic [2:0] CC_PLUS  = 3'd4;
  localparam logic [2:0] CC_MINUS = 3'd5;
  localparam logic [2:0] CC_OVF   = 3'd6;
  localparam logic [2:0] CC_NOVF  = 3'd7;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } status_t;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] result,
  output status_t      status,
  output logic         emits_word,
  output logic         known_op
);

  localparam int LOW = W - 1;

  logic         sub_mode;
  logic         logic_mode;
  logic [W-1:0] b_eff;
  logic [LOW:0] low_sum;
  logic         carry_into_top;
  logic         carry_out_top;
  logic         top_bit;
  logic [W-1:0] arith_res;

  assign sub_mode   = (op == OP_SUB) || (op == OP_CMP);
  assign logic_mode = (op == OP_AND) || (op == OP_TST);
  assign b_eff      = sub_mode ? ~b : b;

  // lower W-1 bits with carry-in; the extra bit is the carry into the top bit
  assign low_sum        = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]}
                          + {{LOW{1'b0}}, sub_mode};
  assign carry_into_top = low_sum[LOW];
  assign top_bit        = a[W-1] ^ b_eff[W-1] ^ carry_into_top;
  assign carry_out_top  = (a[W-1] & b_eff[W-1]) | (carry_into_top & (a[W-1] ^ b_eff[W-1]));
  assign arith_res      = {top_bit, low_sum[LOW-1:0]};

  assign result = logic_mode ? (a & b) : arith_res;

  always_comb begin
    status.z = ~|result;
    status.s = result[W-1];
    status.c = logic_mode ? 1'b0 : carry_out_top;
    status.v = logic_mode ? 1'b0 : (carry_into_top ^ carry_out_top);
  end

  assign emits_word = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
  assign known_op   = sub_mode || logic_mode || (op == OP_ADD);

endmodule

// File: rtl/status_reg.sv
module status_reg
  import alu_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  status_t d,
  output status_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_flag_pkg::*;
(
  input  logic [2:0] cond,
  input  status_t    st,
  output logic       taken
);

  always_comb begin
    unique case (cond)
      CC_ZERO:   taken = st.z;
      CC_NZERO:  taken = ~st.z;
      CC_CARRY:  taken = st.c;
      CC_NCARRY: taken = ~st.c;
      CC_PLUS:   taken = ~st.s;
      CC_MINUS:  taken = st.s;
      CC_OVF:    taken = st.v;
      CC_NOVF:   taken = ~st.v;
      default:   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_flag_branch.sv
module alu_flag_branch
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         flag_we,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_v,
  input  logic [2:0]   cond,
  output logic         taken
);

  logic [W-1:0] dp_result;
  status_t      dp_status;
  status_t      st_q;
  logic         dp_emits;
  logic         dp_known;
  logic         accept;

  alu_datapath #(.W(W)) u_dp (
    .a          (op_a),
    .b          (op_b),
    .op         (op_sel),
    .result     (dp_result),
    .status     (dp_status),
    .emits_word (dp_emits),
    .known_op   (dp_known)
  );

  status_reg u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept && flag_we && dp_known),
    .d     (dp_status),
    .q     (st_q)
  );

  branch_eval u_br (
    .cond  (cond),
    .st    (st_q),
    .taken (taken)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (accept) begin
      res_valid <= dp_emits;
      if (dp_emits) res_data <= dp_result;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign flag_c = st_q.c;
  assign flag_z = st_q.z;
  assign flag_s = st_q.s;
  assign flag_v = st_q.v;

endmodule

// File: rtl/alu_flag_branch_chk.sv
module alu_flag_branch_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   op_sel,
  input logic         flag_we,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_data,
  input logic         flag_c,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_v,
  input logic [2:0]   cond,
  input logic         taken
);

  logic acc;
  logic word_op;
  assign acc     = in_valid && in_ready;
  assign word_op = (op_sel == 3'd0) || (op_sel == 3'd1) || (op_sel == 3'd3);

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && flag_we) |=> $stable({flag_c, flag_z, flag_s, flag_v}));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);

  p_cmp_no_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_sel == 3'd2) |=> !res_valid);

  p_and_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && flag_we && (op_sel == 3'd3 || op_sel == 3'd4)) |=> (!flag_c && !flag_v));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && flag_we && word_op) |=> (flag_z == (res_data == '0)));

  p_sign_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && flag_we && word_op) |=> (flag_s == res_data[W-1]));

  p_bz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 3'd0) |-> (taken == flag_z));

  p_bnv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 3'd7) |-> (taken != flag_v));

endmodule

bind alu_flag_branch alu_flag_branch_chk #(.W(W)) u_chk (.*);

// File: tb/alu_flag_branch_test.sv
module alu_flag_branch_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [2:0]   op_sel = '0;
  logic         flag_we = 1'b0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [W-1:0] res_data;
  logic         flag_c, flag_z, flag_s, flag_v;
  logic [2:0]   cond = '0;
  logic         taken;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [3:0] exp_f = 4'b0;  // {c,z,s,v}

  always #10 clk = ~clk;

  alu_flag_branch #(.W(W)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected result and flags, from the requirements
  function automatic logic [W+4:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op);
    logic [W:0] full;
    logic [W-1:0] r;
    logic c, v;
    c = 0; v = 0; r = '0;
    case (op)
      3'd0: begin
        full = {1'b0, a} + {1'b0, b};
        r = full[W-1:0]; c = full[W];
        v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'd1, 3'd2: begin
        full = {1'b0, a} + {1'b0, ~b} + 1;
        r = full[W-1:0]; c = full[W];
        v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      default: r = a & b;
    endcase
    return {r, c, (r == '0), r[W-1], v, 1'b0};
  endfunction

  function automatic bit cond_exp(input logic [2:0] cc, input logic [3:0] f);
    case (cc)
      3'd0: return f[2];
      3'd1: return !f[2];
      3'd2: return f[3];
      3'd3: return !f[3];
      3'd4: return !f[1];
      3'd5: return f[1];
      3'd6: return f[0];
      default: return !f[0];
    endcase
  endfunction

  task automatic sweep_conds();
    for (int k = 0; k < 8; k++) begin
      cond = 3'(k);
      #1;
      chk(taken == cond_exp(3'(k), exp_f), "R10", {31'b0, taken}, {31'b0, cond_exp(3'(k), exp_f)});
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] op, input bit we);
    logic [W+4:0] m;
    bit exp_v;
    string tag;
    m = model(a, b, op);
    exp_v = (op == 3'd0) || (op == 3'd1) || (op == 3'd3);
    if (!we && op <= 3'd4) tag = "R8";
    else case (op)
      3'd0: tag = "R2";
      3'd1: tag = "R3";
      3'd2: tag = "R6";
      3'd3, 3'd4: tag = "R7";
      default: tag = "R9";
    endcase
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; flag_we = we; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (we && op <= 3'd4) exp_f = m[4:1];
    chk(res_valid == exp_v, tag, {31'b0, res_valid}, {31'b0, exp_v});
    if (exp_v) chk(res_data == m[W+4:5], tag, {24'b0, res_data}, {24'b0, m[W+4:5]});
    chk({flag_c, flag_z, flag_s, flag_v} == exp_f, (op <= 3'd2 && we) ? "R4" : tag,
        {28'b0, flag_c, flag_z, flag_s, flag_v}, {28'b0, exp_f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({flag_c, flag_z, flag_s, flag_v} == 4'b0, "R1", {28'b0, flag_c, flag_z, flag_s, flag_v}, 0);
    chk(res_valid == 1'b0, "R1", {31'b0, res_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", {31'b0, in_ready}, 1);
    sweep_conds();

    run_op(8'hF0, 8'h14, 3'd1, 1);  // R3 worked example
    chk({flag_c, flag_z, flag_s, flag_v} == 4'b1010, "R3", {28'b0, flag_c, flag_z, flag_s, flag_v}, 4'b1010);
    sweep_conds();
    run_op(8'h7F, 8'h01, 3'd0, 1);  // R4 overflow without carry
    sweep_conds();
    run_op(8'hFF, 8'h01, 3'd0, 1);  // R2 carry and zero
    sweep_conds();
    run_op(8'h80, 8'h01, 3'd1, 1);  // R4 overflow with carry
    sweep_conds();
    run_op(8'h05, 8'h05, 3'd2, 1);  // R6 equal compare
    sweep_conds();
    run_op(8'hB1, 8'h08, 3'd4, 1);  // R7 test gives zero
    sweep_conds();
    run_op(8'hC3, 8'h81, 3'd3, 0);  // R8 result without flag write
    run_op(8'h00, 8'h00, 3'd6, 1);  // R9 unknown code
    sweep_conds();

    // R11 back-pressure
    res_ready = 1'b0;
    run_op(8'h12, 8'h34, 3'd0, 1);
    chk(in_ready == 1'b0, "R11", {31'b0, in_ready}, 0);
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b1, "R11", {31'b0, res_valid}, 1);
    chk(res_data == 8'h46, "R11", {24'b0, res_data}, 32'h46);
    res_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R11", {31'b0, in_ready}, 1);
    @(negedge clk);
    chk(res_valid == 1'b0, "R11", {31'b0, res_valid}, 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_op(r[7:0], r[15:8], (r[18:16] > 3'd4 && r[19]) ? r[18:16] : 3'(r[18:16] % 5), r[20] | r[21]);
      cond = r[26:24];
      #1;
      chk(taken == cond_exp(r[26:24], exp_f), "R10", {31'b0, taken}, {31'b0, cond_exp(r[26:24], exp_f)});
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule